// File: doc/BRIEF.md
# Read-Priority Row-Hit Request Scheduler

This block holds the pending memory requests of one DRAM bank in arrival order and, on every cycle, offers one of them for issue. Each request is a read or a write tagged with a row and a column. The open row of the bank is an input. The block uses it to sort the queued entries into row hits and row misses, and it offers the entry with the best standing.

The preferred entry is the oldest read that hits the open row and is free of a hazard. A read has a hazard when an older write to the same row and column is still queued. The next choice is the oldest write that hits the open row. When nothing hits, the oldest entry is offered. The offered entry leaves the queue when the consumer accepts it. The entries left behind close up and keep their order. Requests enter through a valid/ready handshake, and the ready signal drops when the queue is full.

Top module: `rowhit_sched`

## Requirements
- R1: After reset the queue is empty, `out_valid` is 0 and `in_ready` is 1.
- R2: The first choice is the oldest queued read whose row equals `open_row` and that has no hazard. It is offered with `out_is_wr` = 0.
- R3: A read has a hazard only when a write that is older in arrival order has the same row and column. Writes that arrived later never block it.
- R4: When no hazard-free read hit exists, the oldest queued write whose row equals `open_row` is offered, with `out_is_wr` = 1.
- R5: When no entry hits `open_row`, the oldest queued entry is offered, whatever its kind.
- R6: The offered entry is removed when `out_valid` and `out_ready` are both 1. The remaining entries keep their relative order.
- R7: `out_is_wr` gives the kind of the offered request: 1 for a write, 0 for a read.
- R8: With DEPTH entries queued, `in_ready` is 0 and a request on the input is not stored.
- R9: With no entries queued, `out_valid` is 0.
- R10: An enqueue and a dequeue in the same cycle are both accepted. The new entry can be offered no earlier than the next cycle.
- R11: While `out_ready` is 0, the queue is not drained. With `open_row` and the queue unchanged, the offered entry stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present on the input |
| in_ready | output | 1 | Queue can take a request |
| in_is_wr | input | 1 | 1 = write, 0 = read |
| in_row | input | ROW_W | Row of the incoming request |
| in_col | input | COL_W | Column of the incoming request |
| open_row | input | ROW_W | Row currently open in the bank |
| out_valid | output | 1 | An entry is offered |
| out_ready | input | 1 | Consumer takes the offered entry |
| out_is_wr | output | 1 | Command kind of the offered entry |
| out_row | output | ROW_W | Row of the offered entry |
| out_col | output | COL_W | Column of the offered entry |

## Verification
The offered entry is combinational. It is formed from the stored queue and the present `open_row`, so it is due in the same cycle as an `open_row` change. A handshake takes effect at the next rising edge, and its effect on the offered entry is due one cycle later. A request that is enqueued can be offered no earlier than the cycle after the edge that stores it. The bench drives inputs on the falling edge and compares the outputs 1 ns later against a reference queue. It updates that reference queue only when it passes the rising edge, so each check sees exactly the state the edge left behind.

// File: rtl/rowhit_sched.sv
module rowhit_sched #(
  parameter int DEPTH = 8,
  parameter int ROW_W = 4,
  parameter int COL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_is_wr,
  input  logic [ROW_W-1:0] in_row,
  input  logic [COL_W-1:0] in_col,
  input  logic [ROW_W-1:0] open_row,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_is_wr,
  output logic [ROW_W-1:0] out_row,
  output logic [COL_W-1:0] out_col
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic             q_wr  [DEPTH];
  logic [ROW_W-1:0] q_row [DEPTH];
  logic [COL_W-1:0] q_col [DEPTH];
  logic [CW-1:0]    cnt;

  logic [DEPTH-1:0] vld, rd_ok, wr_hit;
  logic             rd_found, wr_found;
  logic [IW-1:0]    sel;
  logic             enq, deq;
  logic [CW-1:0]    wptr;

  assign in_ready  = (cnt != CW'(DEPTH));
  assign out_valid = (cnt != '0);
  assign enq       = in_valid && in_ready;
  assign deq       = out_valid && out_ready;
  assign wptr      = cnt - {{(CW-1){1'b0}}, deq};

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      logic haz;
      haz = 1'b0;
      vld[i] = (CW'(i) < cnt);
      for (int j = 0; j < i; j++)
        if (vld[j] && q_wr[j] && q_row[j] == q_row[i] && q_col[j] == q_col[i])
          haz = 1'b1;
      rd_ok[i]  = vld[i] && !q_wr[i] && q_row[i] == open_row && !haz;
      wr_hit[i] = vld[i] &&  q_wr[i] && q_row[i] == open_row;
    end
  end

  always_comb begin
    rd_found = 1'b0;
    wr_found = 1'b0;
    sel      = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (wr_hit[i]) begin
        wr_found = 1'b1;
        sel      = IW'(i);
      end
    for (int i = DEPTH - 1; i >= 0; i--)
      if (rd_ok[i]) begin
        rd_found = 1'b1;
        sel      = IW'(i);
      end
  end

  assign out_is_wr = q_wr[sel];
  assign out_row   = q_row[sel];
  assign out_col   = q_col[sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        q_wr[i]  <= 1'b0;
        q_row[i] <= '0;
        q_col[i] <= '0;
      end
    end else begin
      if (deq)
        for (int i = 0; i < DEPTH - 1; i++)
          if (IW'(i) >= sel) begin
            q_wr[i]  <= q_wr[i+1];
            q_row[i] <= q_row[i+1];
            q_col[i] <= q_col[i+1];
          end
      if (enq) begin
        q_wr[wptr[IW-1:0]]  <= in_is_wr;
        q_row[wptr[IW-1:0]] <= in_row;
        q_col[wptr[IW-1:0]] <= in_col;
      end
      cnt <= cnt + CW'(enq) - CW'(deq);
    end
  end

  logic any_hit;
  always_comb begin
    any_hit = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (vld[i] && q_row[i] == open_row) any_hit = 1'b1;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R8
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(DEPTH) && !deq) |=> cnt == CW'(DEPTH)); // R8
  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> !out_valid); // R9
  AST_MISS_ONLY_WHEN_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_row != open_row) |-> !any_hit); // R5
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !in_valid) |=>
      (open_row != $past(open_row)) ||
      ($stable(out_row) && $stable(out_col) && $stable(out_is_wr))); // R11

endmodule

// File: tb/rowhit_sched_tb.sv
module rowhit_sched_tb;
  localparam int DEPTH = 8;
  localparam int ROW_W = 4;
  localparam int COL_W = 4;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_is_wr = 0, out_ready = 0;
  logic [ROW_W-1:0] in_row = '0, open_row = '0;
  logic [COL_W-1:0] in_col = '0;
  logic in_ready, out_valid, out_is_wr;
  logic [ROW_W-1:0] out_row;
  logic [COL_W-1:0] out_col;

  always #5 clk = ~clk;

  rowhit_sched #(.DEPTH(DEPTH), .ROW_W(ROW_W), .COL_W(COL_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_is_wr(in_is_wr), .in_row(in_row), .in_col(in_col), .open_row(open_row),
    .out_valid(out_valid), .out_ready(out_ready), .out_is_wr(out_is_wr),
    .out_row(out_row), .out_col(out_col));

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  int m_cnt = 0;
  bit m_wr  [DEPTH];
  int m_row [DEPTH];
  int m_col [DEPTH];

  bit obs_v, obs_wr;
  int obs_row, obs_col;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int pick(output int cls, output bit skipped);
    cls = 3; skipped = 0;
    for (int i = 0; i < m_cnt; i++)
      if (!m_wr[i] && m_row[i] == int'(open_row)) begin
        bit haz = 0;
        for (int j = 0; j < i; j++)
          if (m_wr[j] && m_row[j] == m_row[i] && m_col[j] == m_col[i]) haz = 1;
        if (!haz) begin cls = 1; return i; end
        skipped = 1;
      end
    for (int i = 0; i < m_cnt; i++)
      if (m_wr[i] && m_row[i] == int'(open_row)) begin cls = 2; return i; end
    return 0;
  endfunction

  task automatic cycle(bit iv, bit iw, int ir, int ic, int orow, bit ordy);
    int idx, cls; bit skp, fire, take; string tag;
    in_valid = iv; in_is_wr = iw; in_row = ROW_W'(ir); in_col = COL_W'(ic);
    open_row = ROW_W'(orow); out_ready = ordy;
    #1;
    obs_v = out_valid; obs_wr = out_is_wr; obs_row = int'(out_row); obs_col = int'(out_col);
    chk(in_ready == (m_cnt < DEPTH), "R8", int'(in_ready), int'(m_cnt < DEPTH));
    if (m_cnt == 0) chk(!out_valid, "R9", int'(out_valid), 0);
    else begin
      idx = pick(cls, skp);
      tag = (cls == 1) ? (skp ? "R3" : "R2") : (cls == 2) ? "R4" : "R5";
      chk(out_valid, tag, int'(out_valid), 1);
      chk(out_is_wr == m_wr[idx], "R7", int'(out_is_wr), int'(m_wr[idx]));
      chk(int'(out_row) == m_row[idx] && int'(out_col) == m_col[idx], tag,
          int'(out_row) * 256 + int'(out_col), m_row[idx] * 256 + m_col[idx]);
    end
    fire = (m_cnt != 0) && ordy;
    take = iv && (m_cnt < DEPTH);
    if (fire) begin
      idx = pick(cls, skp);
      for (int i = idx; i < m_cnt - 1; i++) begin
        m_wr[i] = m_wr[i+1]; m_row[i] = m_row[i+1]; m_col[i] = m_col[i+1];
      end
      m_cnt--;
    end
    if (take) begin
      m_wr[m_cnt] = iw; m_row[m_cnt] = ir; m_col[m_cnt] = ic; m_cnt++;
    end
    @(posedge clk); @(negedge clk);
  endtask

  task automatic push(bit iw, int ir, int ic, int orow);
    cycle(1, iw, ir, ic, orow, 0);
  endtask

  task automatic drain(int orow);
    while (m_cnt > 0) cycle(0, 0, 0, 0, orow, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk(!out_valid, "R1", int'(out_valid), 0);
    chk(in_ready, "R1", int'(in_ready), 1);
    @(negedge clk);

    push(1, 1, 1, 1); push(0, 1, 1, 1); push(0, 1, 2, 1);
    cycle(0, 0, 0, 0, 1, 0);
    chk(!obs_wr && obs_col == 2, "R3", obs_col, 2);
    cycle(0, 0, 0, 0, 1, 1);
    cycle(0, 0, 0, 0, 1, 1);
    chk(obs_wr && obs_col == 1, "R4", int'(obs_wr), 1);
    cycle(0, 0, 0, 0, 1, 1);
    chk(!obs_wr && obs_col == 1, "R2", int'(obs_wr), 0);

    push(0, 2, 0, 2); push(1, 2, 0, 2);
    cycle(0, 0, 0, 0, 2, 0);
    chk(!obs_wr, "R3", int'(obs_wr), 0);
    cycle(0, 0, 0, 0, 2, 0);
    chk(!obs_wr && obs_row == 2, "R11", int'(obs_wr), 0);
    drain(2);

    push(1, 3, 1, 3);
    cycle(1, 0, 3, 2, 3, 1);
    chk(obs_wr && obs_col == 1, "R10", int'(obs_wr), 1);
    cycle(0, 0, 0, 0, 3, 0);
    chk(obs_v && !obs_wr && obs_col == 2, "R10", int'(obs_v), 1);
    drain(3);

    push(0, 5, 0, 9); push(1, 6, 0, 9); push(0, 7, 1, 9);
    cycle(0, 0, 0, 0, 6, 1);
    chk(obs_wr && obs_row == 6, "R4", obs_row, 6);
    cycle(0, 0, 0, 0, 9, 1);
    chk(obs_row == 5, "R6", obs_row, 5);
    cycle(0, 0, 0, 0, 9, 1);
    chk(obs_row == 7, "R6", obs_row, 7);

    for (int k = 0; k < DEPTH; k++) push(k[0], k, k, 15);
    cycle(1, 0, 14, 14, 15, 0);
    chk(m_cnt == DEPTH, "R8", m_cnt, DEPTH);
    drain(15);
    chk(m_cnt == 0, "R9", m_cnt, 0);

    for (int k = 0; k < 4000; k++) begin
      int orow;
      orow = int'($urandom_range(3));
      cycle($urandom_range(99) < 55, $urandom_range(1), int'($urandom_range(3)),
            int'($urandom_range(3)), orow, $urandom_range(99) < 45);
    end
    drain(0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule